// File: doc/BRIEF.md
# Serial Audio Output Formatter

This block takes stereo sample pairs from an upstream decoder and sends them out on a three-wire serial port: a bit clock, a frame clock and one serial data line. It runs from one fast clock, the recovered master clock at 256 times the sample rate. As clock master it divides that clock down to a bit clock at 64 times the sample rate and a frame clock at the sample rate, so each half of the frame holds 32 bit slots. As clock slave it takes both port clocks from pins, passes them through a synchronizer and advances one slot on each falling edge of the bit clock. In slave mode the bit clock may pause or run out of step with the master clock.

Static control inputs set the format. They choose the sample resolution, left or right justification, an optional one-slot delay of the first data bit, and the polarity of each port clock. A direct-frame mode sends the full 24-bit sample followed by the validity, user and channel-status flags of that channel. A block-start marker follows the flags, in the place where a parity bit would normally sit. If direct-frame mode is requested while de-emphasis is on, the request is flagged as illegal and the data line stays quiet. Change the configuration only while reset is held.

A new pair is taken through a valid/ready handshake at the start of each left half. When no pair is offered, the previous pair is sent again.

Top module: `sao_formatter`

## Requirements
- R1: With `isMaster`=1 and normal polarity, `sclkOut` has a period of 4 clocks and falls every 4th clock. `lrckOut` toggles every 128 clocks, which is 32 bit periods, and is low during the left half. `clkDrive` is high. After reset the first left half starts at the 4th rising edge.
- R2: With `isMaster`=0, `clkDrive`, `sclkOut` and `lrckOut` are held low. Each falling edge of the internal bit clock, seen after a two-stage synchronizer, advances one slot. A frame-clock level change seen at such an edge restarts at slot 0 of the new half. The bit clock may pause for any length of time without losing position.
- R3: `fmtRes` selects the resolution: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. The sample is MSB-aligned in its 24-bit word and sent MSB first. Word bits below the selected resolution, and every slot outside the data field, are sent as 0.
- R4: In left-justified mode (`fmtRightJust`=0) the MSB is in slot 0 of each half. With `fmtDelay`=1 it moves to slot 1.
- R5: In right-justified mode the LSB of the selected resolution falls in slot 31, the last slot of the half. `fmtDelay` has no effect in this mode.
- R6: `sclkInv` inverts the bit clock and `lrckInv` inverts the frame clock. In master mode this applies to the outputs. In slave mode it applies to how the input pins are read.
- R7: With `fmtDirect`=1 the slot layout is fixed:
  - slots 0 to 23 carry the full 24-bit word MSB first, whatever `fmtRes` says;
  - slot 24 carries V, slot 25 carries U and slot 26 carries C, taken from bits 2, 1 and 0 of that channel's flag input;
  - slot 27 carries the pair's block-start flag `inBlkStart`;
  - slots 28 to 31 are 0.
- R8: When `fmtDirect` and `deemphOn` are both 1, `illegalCfg` is 1 from the first clock after reset and `sdata` stays 0.
- R9: `inReady` is a single-cycle pulse in the cycle before the first slot of each left half. A pair is taken in that cycle if `inValid` is 1. Otherwise the pair held before is sent again.
- R10: `sdata` moves to a slot's bit one clock after the slot begins. In master mode that is one clock after the internal bit clock falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered master clock, 256 times the sample rate |
| rst | input | 1 | Asynchronous reset, active high |
| isMaster | input | 1 | 1 = port clocks generated, 0 = port clocks taken from pins |
| fmtRes | input | 2 | Resolution select (16/18/20/24) |
| fmtRightJust | input | 1 | 1 = right-justified |
| fmtDelay | input | 1 | One-slot delay of the MSB in left-justified mode |
| fmtDirect | input | 1 | Direct-frame mode |
| deemphOn | input | 1 | De-emphasis currently enabled |
| sclkInv | input | 1 | Bit clock polarity invert |
| lrckInv | input | 1 | Frame clock polarity invert |
| sclkIn | input | 1 | Bit clock pin in slave mode |
| lrckIn | input | 1 | Frame clock pin in slave mode |
| inValid | input | 1 | Sample pair offered |
| inLeft | input | 24 | Left sample, MSB-aligned |
| inRight | input | 24 | Right sample, MSB-aligned |
| inLeftVuc | input | 3 | Left flags {V,U,C} |
| inRightVuc | input | 3 | Right flags {V,U,C} |
| inBlkStart | input | 1 | Pair is the first frame of a status block |
| inReady | output | 1 | Pair taken this cycle if valid |
| sclkOut | output | 1 | Bit clock out in master mode |
| lrckOut | output | 1 | Frame clock out in master mode |
| clkDrive | output | 1 | Port clocks are driven by this block |
| sdata | output | 1 | Serial data |
| illegalCfg | output | 1 | Direct-frame requested with de-emphasis on |

## Verification
The pair handover and the last slot of the right half land in the same cycle. The pair register loads on the edge where the old pair's final bit is still being emitted, so a wrong pair there corrupts slot 31 of the right half or slot 0 of the left. The bench keeps a new pair queued across each frame boundary and compares every clock against a model that holds the previous pair for that one slot. In slave mode the frame-clock change and the bit-clock fall are driven together, so a restart and a slot advance fall on the same synchronized edge. A pause in the bit clock checks that position is kept.

// File: rtl/sao_pkg.sv
package sao_pkg;
  localparam int SAO_SLOT_W = 6;

  typedef struct packed {
    logic                  emit;
    logic                  load;
    logic                  half;
    logic [SAO_SLOT_W-1:0] slot;
  } sao_strobe_t;

  typedef struct packed {
    logic       direct;
    logic       rightJust;
    logic       delay;
    logic [1:0] res;
  } sao_fmt_t;

  function automatic int sao_res_bits(logic [1:0] sel);
    case (sel)
      2'd0:    return 16;
      2'd1:    return 18;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/sao_ctrl.sv
module sao_ctrl
  import sao_pkg::*;
#(
  parameter int MCLK_DIV    = 4,
  parameter int HALF_SLOTS  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        isMaster,
  input  logic        sclkInv,
  input  logic        lrckInv,
  input  logic        sclkIn,
  input  logic        lrckIn,
  output logic        sclkOut,
  output logic        lrckOut,
  output logic        clkDrive,
  output sao_strobe_t st
);
  localparam int DIV_W = (MCLK_DIV > 1) ? $clog2(MCLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(MCLK_DIV - 1);
  localparam logic [DIV_W-1:0] DIV_MID  = DIV_W'(MCLK_DIV / 2 - 1);
  localparam logic [SAO_SLOT_W-1:0] SLOT_LAST = SAO_SLOT_W'(HALF_SLOTS - 1);
  localparam logic [SAO_SLOT_W-1:0] SLOT_OVER = SAO_SLOT_W'(HALF_SLOTS);

  logic [DIV_W-1:0] divCnt;
  logic masterBclk;
  logic mTick;
  logic [SYNC_STAGES-1:0] bSync;
  logic [SYNC_STAGES-1:0] lSync;
  logic slvBclk, slvLrck, slvBclkPrev, sTick, newHalf;
  logic [SAO_SLOT_W-1:0] slotCnt;
  logic halfRight;
  logic emitReg;
  logic loadNow;

  // master clock divider
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      divCnt     <= '0;
      masterBclk <= 1'b0;
    end else if (isMaster) begin
      if (divCnt == DIV_LAST) begin
        divCnt     <= '0;
        masterBclk <= 1'b0;
      end else begin
        divCnt <= divCnt + 1'b1;
        if (divCnt == DIV_MID) masterBclk <= 1'b1;
      end
    end
  end

  assign mTick = isMaster && (divCnt == DIV_LAST);

  // slave pin synchronizers
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      bSync       <= '0;
      lSync       <= '0;
      slvBclkPrev <= 1'b0;
    end else begin
      bSync       <= {bSync[SYNC_STAGES-2:0], sclkIn};
      lSync       <= {lSync[SYNC_STAGES-2:0], lrckIn};
      slvBclkPrev <= slvBclk;
    end
  end

  assign slvBclk = bSync[SYNC_STAGES-1] ^ sclkInv;
  assign slvLrck = lSync[SYNC_STAGES-1] ^ lrckInv;
  assign sTick   = !isMaster && slvBclkPrev && !slvBclk;
  assign newHalf = sTick && (slvLrck != halfRight);
  assign loadNow = isMaster ? (mTick && halfRight && (slotCnt == SLOT_LAST))
                            : (newHalf && !slvLrck);

  // slot position
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      slotCnt   <= SLOT_LAST;
      halfRight <= 1'b1;
      emitReg   <= 1'b0;
    end else begin
      emitReg <= mTick || sTick;
      if (mTick) begin
        if (slotCnt == SLOT_LAST) begin
          slotCnt   <= '0;
          halfRight <= ~halfRight;
        end else begin
          slotCnt <= slotCnt + 1'b1;
        end
      end else if (sTick) begin
        if (newHalf) begin
          halfRight <= slvLrck;
          slotCnt   <= '0;
        end else if (slotCnt != SLOT_OVER) begin
          slotCnt <= slotCnt + 1'b1;
        end
      end
    end
  end

  assign sclkOut  = isMaster ? (masterBclk ^ sclkInv) : 1'b0;
  assign lrckOut  = isMaster ? (halfRight ^ lrckInv) : 1'b0;
  assign clkDrive = isMaster;

  assign st.emit = emitReg;
  assign st.load = loadNow;
  assign st.half = halfRight;
  assign st.slot = slotCnt;

  // R9: a load always opens the left half at slot 0
  p_load_opens_left_r9: assert property (@(posedge clk) disable iff (rst)
    loadNow |=> (!halfRight && slotCnt == '0));

  // R1: master bit clock ticks are spaced apart and fall on the tick
  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (rst)
    mTick |=> !mTick);
  p_bclk_falls_r1: assert property (@(posedge clk) disable iff (rst)
    mTick |=> (sclkOut == sclkInv));

  // R2: a frame clock change in slave mode restarts the slot count
  p_slave_restart_r2: assert property (@(posedge clk) disable iff (rst)
    newHalf |=> (slotCnt == '0));

  // R10: data emission follows a slot advance by one clock
  p_emit_follows_r10: assert property (@(posedge clk) disable iff (rst)
    (mTick || sTick) |=> emitReg);
endmodule

// File: rtl/sao_datapath.sv
module sao_datapath
  import sao_pkg::*;
#(
  parameter int WORD_W     = 24,
  parameter int HALF_SLOTS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  sao_strobe_t       st,
  input  sao_fmt_t          cfg,
  input  logic              deemphOn,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inLeft,
  input  logic [WORD_W-1:0] inRight,
  input  logic [2:0]        inLeftVuc,
  input  logic [2:0]        inRightVuc,
  input  logic              inBlkStart,
  output logic              sdata,
  output logic              illegalCfg
);
  localparam int FLAG_V = WORD_W;
  localparam int FLAG_U = WORD_W + 1;
  localparam int FLAG_C = WORD_W + 2;
  localparam int FLAG_Z = WORD_W + 3;

  logic [WORD_W-1:0] leftWord, rightWord, curWord, shifted;
  logic [2:0] leftVuc, rightVuc, curVuc;
  logic blkStart;
  logic nextBit;
  logic inWord;
  int resN, slotI, kI, startI;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      leftWord  <= '0;
      rightWord <= '0;
      leftVuc   <= '0;
      rightVuc  <= '0;
      blkStart  <= 1'b0;
    end else if (st.load && inValid) begin
      leftWord  <= inLeft;
      rightWord <= inRight;
      leftVuc   <= inLeftVuc;
      rightVuc  <= inRightVuc;
      blkStart  <= inBlkStart;
    end
  end

  assign curWord = st.half ? rightWord : leftWord;
  assign curVuc  = st.half ? rightVuc : leftVuc;

  always_comb begin
    resN    = sao_res_bits(cfg.res);
    slotI   = int'(st.slot);
    startI  = HALF_SLOTS - resN;
    kI      = 0;
    inWord  = 1'b0;
    nextBit = 1'b0;
    if (cfg.direct) begin
      if (slotI < WORD_W) begin
        kI     = slotI;
        inWord = 1'b1;
      end
    end else if (cfg.rightJust) begin
      if (slotI >= startI && slotI < HALF_SLOTS) begin
        kI     = slotI - startI;
        inWord = 1'b1;
      end
    end else begin
      if (slotI >= int'(cfg.delay) && (slotI - int'(cfg.delay)) < resN) begin
        kI     = slotI - int'(cfg.delay);
        inWord = 1'b1;
      end
    end
    shifted = curWord << kI;
    if (inWord) begin
      nextBit = shifted[WORD_W-1];
    end else if (cfg.direct) begin
      if (slotI == FLAG_V)      nextBit = curVuc[2];
      else if (slotI == FLAG_U) nextBit = curVuc[1];
      else if (slotI == FLAG_C) nextBit = curVuc[0];
      else if (slotI == FLAG_Z) nextBit = blkStart;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sdata      <= 1'b0;
      illegalCfg <= 1'b0;
    end else begin
      illegalCfg <= cfg.direct && deemphOn;
      if (st.emit) sdata <= illegalCfg ? 1'b0 : nextBit;
    end
  end

  // R8: an illegal request keeps the line quiet
  p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (illegalCfg && st.emit) |=> !sdata);

  // R3: left-justified slots past the data field are zero
  p_pad_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (st.emit && !cfg.direct && !cfg.rightJust && !illegalCfg &&
     int'(st.slot) >= resN + int'(cfg.delay)) |=> !sdata);

  // R5: right-justified slots ahead of the data field are zero
  p_rj_lead_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (st.emit && !cfg.direct && cfg.rightJust && int'(st.slot) < HALF_SLOTS - resN)
    |=> !sdata);

  // R7: direct-frame tail slots are zero
  p_direct_tail_r7: assert property (@(posedge clk) disable iff (rst)
    (st.emit && cfg.direct && int'(st.slot) > FLAG_Z) |=> !sdata);
endmodule

// File: rtl/sao_formatter.sv
module sao_formatter
  import sao_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int HALF_SLOTS  = 32,
  parameter int MCLK_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              isMaster,
  input  logic [1:0]        fmtRes,
  input  logic              fmtRightJust,
  input  logic              fmtDelay,
  input  logic              fmtDirect,
  input  logic              deemphOn,
  input  logic              sclkInv,
  input  logic              lrckInv,
  input  logic              sclkIn,
  input  logic              lrckIn,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inLeft,
  input  logic [WORD_W-1:0] inRight,
  input  logic [2:0]        inLeftVuc,
  input  logic [2:0]        inRightVuc,
  input  logic              inBlkStart,
  output logic              inReady,
  output logic              sclkOut,
  output logic              lrckOut,
  output logic              clkDrive,
  output logic              sdata,
  output logic              illegalCfg
);
  sao_strobe_t st;
  sao_fmt_t    cfg;

  assign cfg.direct    = fmtDirect;
  assign cfg.rightJust = fmtRightJust;
  assign cfg.delay     = fmtDelay;
  assign cfg.res       = fmtRes;
  assign inReady       = st.load;

  sao_ctrl #(
    .MCLK_DIV(MCLK_DIV), .HALF_SLOTS(HALF_SLOTS), .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk(clk), .rst(rst), .isMaster(isMaster), .sclkInv(sclkInv), .lrckInv(lrckInv),
    .sclkIn(sclkIn), .lrckIn(lrckIn), .sclkOut(sclkOut), .lrckOut(lrckOut),
    .clkDrive(clkDrive), .st(st)
  );

  sao_datapath #(
    .WORD_W(WORD_W), .HALF_SLOTS(HALF_SLOTS)
  ) uData (
    .clk(clk), .rst(rst), .st(st), .cfg(cfg), .deemphOn(deemphOn), .inValid(inValid),
    .inLeft(inLeft), .inRight(inRight), .inLeftVuc(inLeftVuc), .inRightVuc(inRightVuc),
    .inBlkStart(inBlkStart), .sdata(sdata), .illegalCfg(illegalCfg)
  );
endmodule

// File: tb/sao_formatter_test.sv
module sao_formatter_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst = 1'b1;
  logic isMaster = 1'b1, fmtRightJust = 1'b0, fmtDelay = 1'b0, fmtDirect = 1'b0;
  logic deemphOn = 1'b0, sclkInv = 1'b0, lrckInv = 1'b0, sclkIn = 1'b0, lrckIn = 1'b0;
  logic [1:0] fmtRes = 2'd3;
  logic inValid = 1'b0, inBlkStart = 1'b0;
  logic [23:0] inLeft = '0, inRight = '0;
  logic [2:0] inLeftVuc = '0, inRightVuc = '0;
  logic inReady, sclkOut, lrckOut, clkDrive, sdata, illegalCfg;

  sao_formatter uut (
    .clk(clk), .rst(rst), .isMaster(isMaster), .fmtRes(fmtRes), .fmtRightJust(fmtRightJust),
    .fmtDelay(fmtDelay), .fmtDirect(fmtDirect), .deemphOn(deemphOn), .sclkInv(sclkInv),
    .lrckInv(lrckInv), .sclkIn(sclkIn), .lrckIn(lrckIn), .inValid(inValid), .inLeft(inLeft),
    .inRight(inRight), .inLeftVuc(inLeftVuc), .inRightVuc(inRightVuc), .inBlkStart(inBlkStart),
    .inReady(inReady), .sclkOut(sclkOut), .lrckOut(lrckOut), .clkDrive(clkDrive),
    .sdata(sdata), .illegalCfg(illegalCfg)
  );

  int checks = 0;
  int errors = 0;

  logic [23:0] qL[$], qR[$];
  logic [2:0]  qLv[$], qRv[$];
  logic        qZ[$];
  logic [23:0] cL, cR;
  logic [2:0]  cLv, cRv;
  logic        cZ;

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic expBit(int s, bit h, logic [23:0] l, logic [23:0] r,
                                  logic [2:0] lv, logic [2:0] rv, logic z);
    logic [23:0] w;
    logic [2:0] f;
    int res, k;
    w = h ? r : l;
    f = h ? rv : lv;
    case (fmtRes)
      2'd0: res = 16;
      2'd1: res = 18;
      2'd2: res = 20;
      default: res = 24;
    endcase
    if (fmtDirect && deemphOn) return 1'b0;
    if (fmtDirect) begin
      if (s < 24) return w[23-s];
      if (s == 24) return f[2];
      if (s == 25) return f[1];
      if (s == 26) return f[0];
      if (s == 27) return z;
      return 1'b0;
    end
    if (fmtRightJust) k = s - (32 - res);
    else k = s - (fmtDelay ? 1 : 0);
    if (k >= 0 && k < res) return w[23-k];
    return 1'b0;
  endfunction

  task automatic pushPair(logic [23:0] l, logic [23:0] r, logic [2:0] lv, logic [2:0] rv, logic z);
    qL.push_back(l); qR.push_back(r); qLv.push_back(lv); qRv.push_back(rv); qZ.push_back(z);
  endtask

  task automatic driveFromQueue();
    if (qL.size() > 0) begin
      inValid = 1'b1; inLeft = qL[0]; inRight = qR[0];
      inLeftVuc = qLv[0]; inRightVuc = qRv[0]; inBlkStart = qZ[0];
    end else begin
      inValid = 1'b0;
    end
  endtask

  task automatic applyReset();
    rst = 1'b1;
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset inReady", inReady, 1'b0);
    chk("R8 reset illegalCfg", illegalCfg, 1'b0);
    chk("R10 reset sdata", sdata, 1'b0);
    rst = 1'b0;
    cL = '0; cR = '0; cLv = '0; cRv = '0; cZ = 1'b0;
  endtask

  task automatic runMaster(string tag, int frames);
    logic [23:0] dL, dR;
    logic [2:0] dLv, dRv;
    logic dZ, expL, expD;
    int g;
    isMaster = 1'b1;
    applyReset();
    driveFromQueue();
    for (int e = 1; e <= frames * 256 + 8; e++) begin
      @(negedge clk);
      dL = cL; dR = cR; dLv = cLv; dRv = cRv; dZ = cZ;
      if (e >= 4 && ((e - 4) % 256) == 0 && inValid) begin
        cL = inLeft; cR = inRight; cLv = inLeftVuc; cRv = inRightVuc; cZ = inBlkStart;
        void'(qL.pop_front()); void'(qR.pop_front()); void'(qLv.pop_front());
        void'(qRv.pop_front()); void'(qZ.pop_front());
      end
      expL = (e < 4) ? 1'b1 : ((((e - 4) / 128) % 2) == 1);
      chk("R1 R6 sclkOut", sclkOut, ((e % 4) >= 2) ^ sclkInv);
      chk("R1 R6 lrckOut", lrckOut, expL ^ lrckInv);
      chk("R1 clkDrive", clkDrive, 1'b1);
      chk("R9 inReady", inReady, (e % 256) == 3);
      chk("R8 illegalCfg", illegalCfg, fmtDirect && deemphOn);
      if (e < 5) expD = 1'b0;
      else begin
        g = (e - 5) / 4;
        expD = expBit(g % 32, ((g / 32) % 2) == 1, dL, dR, dLv, dRv, dZ);
      end
      chk({tag, " sdata"}, sdata, expD);
      driveFromQueue();
    end
  endtask

  task automatic runSlave();
    logic [23:0] aL, aR, bL, bR, uL, uR;
    isMaster = 1'b0; fmtRes = 2'd3; fmtRightJust = 1'b0; fmtDelay = 1'b1;
    fmtDirect = 1'b0; deemphOn = 1'b0; sclkInv = 1'b1; lrckInv = 1'b0;
    sclkIn = 1'b1 ^ sclkInv; lrckIn = 1'b1 ^ lrckInv;
    aL = 24'hB4E21D; aR = 24'h6A15C9; bL = 24'h1F0E8B; bR = 24'hD37A42;
    applyReset();
    inValid = 1'b1; inLeft = aL; inRight = aR; inLeftVuc = '0; inRightVuc = '0; inBlkStart = 1'b0;
    repeat (5) @(negedge clk);
    for (int f = 0; f < 3; f++) begin
      if (f == 1) begin inLeft = bL; inRight = bR; end
      if (f == 2) begin inValid = 1'b0; inLeft = 24'hFFFFFF; inRight = 24'hFFFFFF; end
      uL = (f == 0) ? aL : bL;
      uR = (f == 0) ? aR : bR;
      for (int h = 0; h < 2; h++) begin
        for (int b = 0; b < 32; b++) begin
          sclkIn = 1'b0 ^ sclkInv;
          lrckIn = h[0] ^ lrckInv;
          repeat (5) @(negedge clk);
          chk("R2 R4 R6 R9 slave sdata", sdata, expBit(b, h[0], uL, uR, 3'b0, 3'b0, 1'b0));
          chk("R2 slave sclkOut", sclkOut, 1'b0);
          chk("R2 slave lrckOut", lrckOut, 1'b0);
          chk("R2 slave clkDrive", clkDrive, 1'b0);
          sclkIn = 1'b1 ^ sclkInv;
          repeat (5) @(negedge clk);
          if (f == 0 && h == 0 && b == 10) repeat (40) @(negedge clk);
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R3 R4 R9 R10: 24-bit left-justified, two pairs then repeats
    fmtRes = 2'd3; fmtRightJust = 1'b0; fmtDelay = 1'b0;
    pushPair(24'hC3A5F1, 24'h5A0F3C, 3'b000, 3'b000, 1'b0);
    pushPair(24'h81FF7E, 24'h3CC3A5, 3'b000, 3'b000, 1'b0);
    runMaster("R3 R4 R9 R10 lj24", 4);
    // R3 R4: 16-bit with one-slot delay
    fmtRes = 2'd0; fmtDelay = 1'b1;
    pushPair(24'hFFFFFF, 24'h8000FF, 3'b000, 3'b000, 1'b0);
    pushPair(24'h7FC0A3, 24'hA5A5A5, 3'b000, 3'b000, 1'b0);
    runMaster("R3 R4 lj16 delayed", 3);
    // R5: 18-bit right-justified
    fmtRes = 2'd1; fmtRightJust = 1'b1; fmtDelay = 1'b0;
    pushPair(24'hE7C3FF, 24'h13579B, 3'b000, 3'b000, 1'b0);
    pushPair(24'h2468AC, 24'hFDB975, 3'b000, 3'b000, 1'b0);
    runMaster("R3 R5 rj18", 3);
    // R5 R6: 20-bit right-justified, delay ignored, both clocks inverted
    fmtRes = 2'd2; fmtDelay = 1'b1; sclkInv = 1'b1; lrckInv = 1'b1;
    pushPair(24'hFFFFF0, 24'h0000FF, 3'b000, 3'b000, 1'b0);
    pushPair(24'h9C3E71, 24'h62D0B8, 3'b000, 3'b000, 1'b0);
    runMaster("R5 R6 rj20", 3);
    // R7: direct-frame mode with flags and block start on first pair
    sclkInv = 1'b0; lrckInv = 1'b0; fmtRightJust = 1'b0; fmtDelay = 1'b0;
    fmtRes = 2'd0; fmtDirect = 1'b1;
    pushPair(24'hA1B2C3, 24'h3C2B1A, 3'b101, 3'b010, 1'b1);
    pushPair(24'h55AA0F, 24'hF0AA55, 3'b011, 3'b110, 1'b0);
    runMaster("R7 direct", 3);
    // R8: direct-frame requested while de-emphasis is on
    deemphOn = 1'b1;
    pushPair(24'hFFFFFF, 24'hFFFFFF, 3'b111, 3'b111, 1'b1);
    runMaster("R8 illegal", 2);
    // R2 R6: slave mode with inverted bit clock pin and a pause
    runSlave();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule